// File: doc/BRIEF.md
# Breathing PWM Generator

This block produces a single pulse-width-modulated bit for driving indicator LEDs. A free-running counter sweeps from zero up to a programmed period minus one and then wraps. The output is high while the count is below an active threshold. The output bit may fan out to any number of pins. That routing, like the bus adapter, lives outside this block. Two configuration words arrive on plain write-enable ports.

The active threshold has two sources. It is either a fixed value from the timing word, or a triangle sweep that the block generates itself. The sweep moves by one step at every counter wrap. It climbs from a programmed floor to a programmed ceiling and then descends again. On an LED this gives a slow "breathing" brightness. A long period blinks visibly. A short period with a small duty looks like a steady, dim glow. Software must keep the sweep disabled while it changes the floor or ceiling. It must also keep floor < ceiling < period, and both the fixed threshold and the floor above 1.

Top module: `pwm_breather`

## Requirements
- R1: A write on `tim_we` loads the period from `tim_wdata[31:16]` and the fixed threshold from `tim_wdata[15:0]`. A write on `rmp_we` loads the sweep enable from `rmp_wdata[31]`, the floor (15 bits, zero-extended) from `rmp_wdata[30:16]` and the ceiling from `rmp_wdata[15:0]`. Written values are in use from the clock after the write.
- R2: The counter steps by one each clock from 0 to period−1 and then returns to 0. A period of 0 or 1 holds the counter at 0.
- R3: `pwm_out` is registered. On each clock it takes the value (count < active threshold), using the count and threshold of the previous cycle. A threshold of 0 keeps the output low.
- R4: With the sweep disabled, the active threshold is the fixed threshold. In steady state, every window of period clocks holds exactly that many high cycles.
- R5: With the sweep enabled, the fixed threshold has no effect on the output.
- R6: In the clock after the enable first reads 1, the swept threshold is loaded with the floor and its direction is set to rising.
- R7: While the sweep is enabled, the swept threshold changes by exactly one at each counter wrap and holds otherwise. It rises until it reaches the ceiling, then falls until it reaches the floor, and repeats.
- R8: A synchronous active-high `rst` clears all configuration and state, and `pwm_out` is low in the clock after `rst` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tim_we | input | 1 | Write strobe for the timing word |
| tim_wdata | input | 32 | Timing word: period [31:16], fixed threshold [15:0] |
| rmp_we | input | 1 | Write strobe for the sweep word |
| rmp_wdata | input | 32 | Sweep word: enable [31], floor [30:16], ceiling [15:0] |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A wrong count or wrap point appears at `pwm_out` within one period. The high run then starts or ends on the wrong clock, and the duty measured over a window no longer matches the threshold. A sweep that loads the wrong value, steps twice, or turns at the wrong bound changes the length of the high run in the very next period. So any deviation shows at the port one period after it happens. Comparing `pwm_out` against the model on every clock therefore localises an error to the period in which it began.

// File: rtl/pwm_breather_pkg.sv
package pwm_breather_pkg;
  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } ramp_dir_e;

  localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned DW = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tim_we,
  input  logic [DW-1:0]    tim_wdata,
  input  logic             rmp_we,
  input  logic [DW-1:0]    rmp_wdata,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] fixed_thr_o,
  output logic             ramp_en_o,
  output logic [CNT_W-1:0] ramp_min_o,
  output logic [CNT_W-1:0] ramp_max_o
);
  localparam int unsigned MIN_W = CNT_W - 1;

  logic [MIN_W-1:0] min_q;

  // timing word: period in the upper half, fixed threshold in the lower half
  always_ff @(posedge clk) begin
    if (rst) begin
      period_o    <= '0;
      fixed_thr_o <= '0;
    end else if (tim_we) begin
      period_o    <= tim_wdata[DW-1:CNT_W];
      fixed_thr_o <= tim_wdata[CNT_W-1:0];
    end
  end

  // sweep word: enable at the top bit, floor below it, ceiling in the low half
  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_en_o  <= 1'b0;
      min_q      <= '0;
      ramp_max_o <= '0;
    end else if (rmp_we) begin
      ramp_en_o  <= rmp_wdata[DW-1];
      min_q      <= rmp_wdata[DW-2:CNT_W];
      ramp_max_o <= rmp_wdata[CNT_W-1:0];
    end
  end

  assign ramp_min_o = {1'b0, min_q};
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W:0] cnt_inc;

  // one extra bit so that period 0 and the all-ones count compare cleanly
  assign cnt_inc = {1'b0, cnt_o} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap_o  = (cnt_inc >= {1'b0, period_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (wrap_o) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_ramp_gen.sv
module pwm_ramp_gen
  import pwm_breather_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] thr_o,
  output ramp_dir_e        dir_o
);
  logic armed_q;
  logic do_load;
  logic do_step;
  logic at_top;
  logic at_bottom;

  assign do_load   = en_i & ~armed_q;
  assign do_step   = en_i & armed_q & wrap_i;
  assign at_top    = (thr_o >= max_i);
  assign at_bottom = (thr_o <= min_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= en_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_o <= '0;
      dir_o <= DIR_RISE;
    end else if (do_load) begin
      thr_o <= min_i;
      dir_o <= DIR_RISE;
    end else if (do_step) begin
      if (dir_o == DIR_RISE) begin
        if (at_top) begin
          dir_o <= DIR_FALL;
          thr_o <= thr_o - 1'b1;
        end else begin
          thr_o <= thr_o + 1'b1;
        end
      end else begin
        if (at_bottom) begin
          dir_o <= DIR_RISE;
          thr_o <= thr_o + 1'b1;
        end else begin
          thr_o <= thr_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_breather.sv
module pwm_breather
  import pwm_breather_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  localparam int unsigned DW = 2 * CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tim_we,
  input  logic [DW-1:0] tim_wdata,
  input  logic          rmp_we,
  input  logic [DW-1:0] rmp_wdata,
  output logic          pwm_out
);
  logic [CNT_W-1:0] period_w;
  logic [CNT_W-1:0] fixed_thr_w;
  logic             ramp_en_w;
  logic [CNT_W-1:0] ramp_min_w;
  logic [CNT_W-1:0] ramp_max_w;
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic [CNT_W-1:0] swept_thr_w;
  ramp_dir_e        dir_w;
  logic [CNT_W-1:0] thr_sel;

  pwm_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .tim_we     (tim_we),
    .tim_wdata  (tim_wdata),
    .rmp_we     (rmp_we),
    .rmp_wdata  (rmp_wdata),
    .period_o   (period_w),
    .fixed_thr_o(fixed_thr_w),
    .ramp_en_o  (ramp_en_w),
    .ramp_min_o (ramp_min_w),
    .ramp_max_o (ramp_max_w)
  );

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .period_i(period_w),
    .cnt_o   (cnt_w),
    .wrap_o  (wrap_w)
  );

  pwm_ramp_gen #(.CNT_W(CNT_W)) u_ramp (
    .clk   (clk),
    .rst   (rst),
    .en_i  (ramp_en_w),
    .min_i (ramp_min_w),
    .max_i (ramp_max_w),
    .wrap_i(wrap_w),
    .thr_o (swept_thr_w),
    .dir_o (dir_w)
  );

  assign thr_sel = ramp_en_w ? swept_thr_w : fixed_thr_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= (cnt_w < thr_sel);
    end
  end
endmodule

// File: rtl/pwm_breather_chk.sv
module pwm_breather_chk
  import pwm_breather_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             ramp_en,
  input logic [CNT_W-1:0] ramp_min,
  input logic [CNT_W-1:0] swept_thr,
  input ramp_dir_e        dir,
  input logic [CNT_W-1:0] thr_sel
);
  logic [CNT_W:0] nxt;
  assign nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  // R8: output low after reset
  a_r8_reset_low: assert property (@(posedge clk) rst |=> !pwm_out);

  // R2: counter returns to zero after reaching period-1
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (nxt >= {1'b0, period}) |=> (cnt == '0));

  // R2: counter advances by one below the wrap point
  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (nxt < {1'b0, period}) |=> (cnt == $past(cnt) + 1'b1));

  // R3: zero threshold keeps the output low
  a_r3_zero_thr_low: assert property (@(posedge clk) disable iff (rst)
    (thr_sel == '0) |=> !pwm_out);

  // R6: enabling the sweep loads the floor, rising
  a_r6_load_floor: assert property (@(posedge clk) disable iff (rst)
    $rose(ramp_en) |=> (swept_thr == $past(ramp_min) && dir == DIR_RISE));

  // R7: swept threshold holds between wraps
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    (ramp_en && $past(ramp_en) && !(nxt >= {1'b0, period})) |=> $stable(swept_thr));

  // R7: swept threshold moves by exactly one on a wrap
  a_r7_step_one: assert property (@(posedge clk) disable iff (rst)
    (ramp_en && $past(ramp_en) && (nxt >= {1'b0, period})) |=>
    (swept_thr == $past(swept_thr) + 1'b1 || swept_thr == $past(swept_thr) - 1'b1));
endmodule

bind pwm_breather pwm_breather_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwm_out  (pwm_out),
  .cnt      (cnt_w),
  .period   (period_w),
  .ramp_en  (ramp_en_w),
  .ramp_min (ramp_min_w),
  .swept_thr(swept_thr_w),
  .dir      (dir_w),
  .thr_sel  (thr_sel)
);

// File: tb/pwm_breather_tb.sv
module pwm_breather_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tim_we = 1'b0;
  logic [31:0] tim_wdata = '0;
  logic        rmp_we = 1'b0;
  logic [31:0] rmp_wdata = '0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_breather u_dut (
    .clk      (clk),
    .rst      (rst),
    .tim_we   (tim_we),
    .tim_wdata(tim_wdata),
    .rmp_we   (rmp_we),
    .rmp_wdata(rmp_wdata),
    .pwm_out  (pwm_out)
  );

  // behavioural reference model
  int m_period, m_fthr, m_en, m_min, m_max;
  int m_cnt, m_thr, m_up, m_armed, m_out;

  initial begin
    m_period = 0; m_fthr = 0; m_en = 0; m_min = 0; m_max = 0;
    m_cnt = 0; m_thr = 0; m_up = 1; m_armed = 0; m_out = 0;
  end

  always @(posedge clk) begin
    int sel, wrap, n_cnt, n_thr, n_up;
    if (rst) begin
      m_period = 0; m_fthr = 0; m_en = 0; m_min = 0; m_max = 0;
      m_cnt = 0; m_thr = 0; m_up = 1; m_armed = 0; m_out = 0;
    end else begin
      sel   = m_en ? m_thr : m_fthr;
      wrap  = (m_cnt + 1 >= m_period);
      n_cnt = wrap ? 0 : m_cnt + 1;
      n_thr = m_thr;
      n_up  = m_up;
      if (m_en && !m_armed) begin
        n_thr = m_min; n_up = 1;
      end else if (m_en && wrap) begin
        if (m_up) begin
          if (m_thr >= m_max) begin n_up = 0; n_thr = m_thr - 1; end
          else n_thr = m_thr + 1;
        end else begin
          if (m_thr <= m_min) begin n_up = 1; n_thr = m_thr + 1; end
          else n_thr = m_thr - 1;
        end
      end
      m_out   = (m_cnt < sel);
      m_cnt   = n_cnt;
      m_thr   = n_thr & 16'hFFFF;
      m_up    = n_up;
      m_armed = m_en;
      if (tim_we) begin
        m_period = tim_wdata[31:16];
        m_fthr   = tim_wdata[15:0];
      end
      if (rmp_we) begin
        m_en  = rmp_wdata[31];
        m_min = rmp_wdata[30:16];
        m_max = rmp_wdata[15:0];
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (pwm_out !== m_out[0]) begin
      errors++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", cur_req, pwm_out, m_out[0], $time);
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_tim(input int per, input int thr);
    @(negedge clk);
    tim_we = 1'b1;
    tim_wdata = {per[15:0], thr[15:0]};
    @(negedge clk);
    tim_we = 1'b0;
  endtask

  task automatic write_rmp(input int en, input int lo, input int hi);
    @(negedge clk);
    rmp_we = 1'b1;
    rmp_wdata = {en[0], lo[14:0], hi[15:0]};
    @(negedge clk);
    rmp_we = 1'b0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out === 1'b1) hi++;
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_sim();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check_eq("R8", pwm_out, 0);
    rst = 1'b0;

    cur_req = "R1";
    write_tim(12, 6);
    repeat (30) @(negedge clk);
    count_high(12, hi);
    check_eq("R1", hi, 6);

    cur_req = "R4";
    write_tim(10, 3);
    repeat (25) @(negedge clk);
    count_high(10, hi);
    check_eq("R4", hi, 3);

    cur_req = "R3";
    write_tim(6, 5);
    repeat (15) @(negedge clk);
    count_high(6, hi);
    check_eq("R3", hi, 5);

    cur_req = "R2";
    write_tim(0, 3);
    repeat (5) @(negedge clk);
    count_high(10, hi);
    check_eq("R2", hi, 10);
    write_tim(1, 0);
    repeat (5) @(negedge clk);
    count_high(10, hi);
    check_eq("R3", hi, 0);

    cur_req = "R6";
    write_tim(8, 3);
    write_rmp(1, 2, 5);
    cur_req = "R7";
    repeat (8 * 20) @(negedge clk);

    cur_req = "R5";
    write_tim(8, 7);
    repeat (8 * 12) @(negedge clk);

    cur_req = "R4";
    write_rmp(0, 2, 5);
    repeat (20) @(negedge clk);
    count_high(8, hi);
    check_eq("R4", hi, 7);

    cur_req = "R6";
    write_rmp(0, 3, 6);
    write_rmp(1, 3, 6);
    cur_req = "R7";
    repeat (8 * 16) @(negedge clk);

    cur_req = "R8";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_eq("R8", pwm_out, 0);
    @(negedge clk);
    rst = 1'b0;
    count_high(20, hi);
    check_eq("R8", hi, 0);

    finish_sim();
  end
endmodule